// File: doc/BRIEF.md
# Timer Slave-Mode Reset Controller

This block is an up-counting timer that has a programmable prescaler, an auto-reload limit and a bank of compare values. The limit and the compare values are preloaded. A slave controller watches a raw external trigger pin. When the trigger is qualified for the restart function, the chosen edge of that pin restarts the counter and its prescaler in the middle of a period. The restart also sets a sticky trigger flag, which can drive an interrupt line and a one-cycle DMA request. The update-request-source control decides whether the restart also raises an update event. An update event copies the preloaded limit and compare values into their active registers.

The raw pin is synchronised by a two-flop chain. An edge state machine then follows the synchronised level. It has two states, `LVL_LO` and `LVL_HI`. The transition `LVL_LO -> LVL_HI` is a rise and `LVL_HI -> LVL_LO` is a fall. A run state machine has two states, `CTL_STOP` and `CTL_RUN`. It moves `CTL_STOP -> CTL_RUN` when `cnt_en` is high and `CTL_RUN -> CTL_STOP` when `cnt_en` is low. It gates both counting and trigger acceptance. A flag state machine has two states, `FLG_CLEAR` and `FLG_SET`. It moves `FLG_CLEAR -> FLG_SET` on an accepted trigger, and `FLG_SET -> FLG_CLEAR` on a clear strobe when no trigger arrives in the same cycle.

Top module: `slave_reset_timer`

## Requirements
- R1: After reset, the following outputs are 0: `cnt`, `uev`, `trig_flag`, `irq` and `dma_req`. Every bit of `arr_act` and `cmp_act` is 1.
- R2: The run state follows `cnt_en` one cycle late. In the run state, `cnt` advances once every `psc_div`+1 cycles. In the stopped state, `cnt` holds its value.
- R3: When `cnt` equals `arr_act` on a counting step, the next value of `cnt` is 0. In that same cycle `uev` pulses, and `arr_act` and `cmp_act` take the values of `arr_pre` and `ccr_pre`. This happens whatever the value of `urs`.
- R4: A trigger is accepted only when `slv_mode` is 3'b100 and `trig_sel` is 5'b00101. Any other value of either field makes edges on `trig_in` ignored.
- R5: The edge is chosen by {`edge_both`,`edge_inv`}. The value 2'b00 selects rising edges only. The value 2'b01 selects falling edges only. The values 2'b10 and 2'b11 select both edges.
- R6: An accepted edge clears `cnt` and the prescaler at the third rising clock edge after `trig_in` changes. The counter then restarts from 0 with a full prescaler period.
- R7: With `urs`=0, an accepted trigger pulses `uev` in the cycle the counter clears. It also loads `arr_pre` and `ccr_pre` into the active registers.
- R8: With `urs`=1, an accepted trigger still clears the counter and sets the flag. It raises no `uev`, and the active registers keep their values.
- R9: `trig_flag` stays set until `flag_clr` is high for a cycle. If `flag_clr` and an accepted trigger occur in the same cycle, the flag stays set.
- R10: `irq` is high while both `trig_flag` and `tie` are high. `dma_req` is a one-cycle pulse that rises together with the flag's set cycle, and only when `tde` is high.
- R11: A trigger edge that is detected while the run state is stopped does not clear the counter and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable |
| trig_in | input | 1 | Raw, unsynchronised trigger pin |
| edge_inv | input | 1 | Selects the falling edge instead of the rising edge |
| edge_both | input | 1 | Accepts both edges |
| slv_mode | input | 3 | Slave function select (3'b100 = restart) |
| trig_sel | input | 5 | Trigger source select (5'b00101 = `trig_in`) |
| urs | input | 1 | 1 = a trigger restart raises no update event |
| psc_div | input | 16 | Prescaler divide value minus one |
| arr_pre | input | 16 | Preloaded auto-reload limit |
| ccr_pre | input | 32 | Preloaded compare values, channel 0 in the low bits |
| tie | input | 1 | Trigger interrupt enable |
| tde | input | 1 | Trigger DMA enable |
| flag_clr | input | 1 | Strobe that clears the trigger flag |
| cnt | output | 16 | Counter value |
| uev | output | 1 | Update event pulse |
| trig_flag | output | 1 | Sticky trigger flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |
| arr_act | output | 16 | Active auto-reload limit |
| cmp_act | output | 32 | Active compare values |

## Verification
The bench sweeps every edge-select setting against both edge directions. It checks that each combination either restarts the counter or lets it advance by exactly three steps. A design with the polarity decoding swapped would restart on the wrong transition. The bench samples the counter one cycle before and at the third clock edge after the pin changes, so a synchroniser that is one flop too short or too long shows up as a wrong count. It also drives a flag clear in the same cycle as a trigger, sends a trigger with `urs` high while a different limit is preloaded, and sends triggers while the counter is stopped or the mode or source is wrong. A flag state machine that gives the clear strobe priority would lose the flag. A design that ignores `urs` would load the new limit. A design that does not gate the trigger would clear the frozen count. Last, the bench sets a prescaler of three and checks that, after a restart, the first count comes a full three cycles later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {LVL_LO, LVL_HI} lvl_e;
    typedef enum logic {CTL_STOP, CTL_RUN} ctl_e;
    typedef enum logic {FLG_CLEAR, FLG_SET} flg_e;

    localparam logic [2:0] MODE_RESTART = 3'b100;
    localparam logic [4:0] SRC_PIN     = 5'b00101;
endpackage

// File: rtl/trig_sync.sv
module trig_sync
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic edge_inv,
    input  logic edge_both,
    output logic hit
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   sync;
    lvl_e                   lvl_q, lvl_d;
    logic                   rise, fall;

    // synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], din};
    end
    assign sync = chain[SYNC_STAGES-1];

    // level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LO;
        else        lvl_q <= lvl_d;
    end

    // next-state and edge outputs
    always_comb begin
        lvl_d = lvl_q;
        rise  = 1'b0;
        fall  = 1'b0;
        unique case (lvl_q)
            LVL_LO: if (sync)  begin lvl_d = LVL_HI; rise = 1'b1; end
            LVL_HI: if (!sync) begin lvl_d = LVL_LO; fall = 1'b1; end
        endcase
    end

    // R5 edge choice
    always_comb begin
        if (edge_both)     hit = rise | fall;
        else if (edge_inv) hit = fall;
        else               hit = rise;
    end

    a_r5_single_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !edge_both && !edge_inv) |-> (sync && lvl_q == LVL_LO));
endmodule

// File: rtl/slave_ctl.sv
module slave_ctl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       hit,
    input  logic [2:0] slv_mode,
    input  logic [4:0] trig_sel,
    input  logic       flag_clr,
    input  logic       tie,
    input  logic       tde,
    output logic       run,
    output logic       trig_evt,
    output logic       trig_flag,
    output logic       irq,
    output logic       dma_req
);
    ctl_e ctl_q, ctl_d;
    flg_e flg_q, flg_d;
    logic dma_q;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_STOP;
            flg_q <= FLG_CLEAR;
            dma_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            flg_q <= flg_d;
            dma_q <= trig_evt & tde;
        end
    end

    // run machine (R2, R11)
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_STOP: if (cnt_en)  ctl_d = CTL_RUN;
            CTL_RUN:  if (!cnt_en) ctl_d = CTL_STOP;
        endcase
    end

    // trigger qualification (R4, R11)
    assign trig_evt = (ctl_q == CTL_RUN) && (slv_mode == MODE_RESTART)
                      && (trig_sel == SRC_PIN) && hit;

    // flag machine (R9): a new trigger wins over the clear
    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_CLEAR: if (trig_evt)              flg_d = FLG_SET;
            FLG_SET:   if (flag_clr && !trig_evt) flg_d = FLG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        run       = (ctl_q == CTL_RUN);
        trig_flag = (flg_q == FLG_SET);
        irq       = trig_flag & tie;
        dma_req   = dma_q;
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !flag_clr) |=> trig_flag);
    a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && run && slv_mode == MODE_RESTART && trig_sel == SRC_PIN && flag_clr) |=> trig_flag);
    a_r10_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> trig_flag);
    a_r11_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig_flag) |=> !trig_flag);
endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc_div,
    input  logic [CNT_W-1:0] arr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step = run && (psc_q >= psc_div);
    assign ovf  = step && !clr && (cnt_q == arr);
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            psc_q <= '0;
            cnt_q <= (cnt_q == arr) ? '0 : cnt_q + 1'b1;
        end else if (run) begin
            psc_q <= psc_q + 1'b1;
        end
    end

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && psc_q == '0));
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && psc_q >= psc_div && cnt_q == arr) |=> (cnt_q == '0));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/preload_bank.sv
module preload_bank #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [CNT_W-1:0]        arr_pre,
    input  logic [NUM_CH*CNT_W-1:0] ccr_pre,
    output logic [CNT_W-1:0]        arr_act,
    output logic [NUM_CH*CNT_W-1:0] cmp_act
);
    logic [CNT_W-1:0] cmp_q [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_act <= '1;
            for (int ch = 0; ch < NUM_CH; ch++) cmp_q[ch] <= '1;
        end else if (load) begin
            arr_act <= arr_pre;
            for (int ch = 0; ch < NUM_CH; ch++) cmp_q[ch] <= ccr_pre[ch*CNT_W +: CNT_W];
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
        assign cmp_act[ch*CNT_W +: CNT_W] = cmp_q[ch];
    end
endmodule

// File: rtl/slave_reset_timer.sv
module slave_reset_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    input  logic                    trig_in,
    input  logic                    edge_inv,
    input  logic                    edge_both,
    input  logic [2:0]              slv_mode,
    input  logic [4:0]              trig_sel,
    input  logic                    urs,
    input  logic [PSC_W-1:0]        psc_div,
    input  logic [CNT_W-1:0]        arr_pre,
    input  logic [NUM_CH*CNT_W-1:0] ccr_pre,
    input  logic                    tie,
    input  logic                    tde,
    input  logic                    flag_clr,
    output logic [CNT_W-1:0]        cnt,
    output logic                    uev,
    output logic                    trig_flag,
    output logic                    irq,
    output logic                    dma_req,
    output logic [CNT_W-1:0]        arr_act,
    output logic [NUM_CH*CNT_W-1:0] cmp_act
);
    logic hit, run, trig_evt, ovf, load, uev_q;

    trig_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_in),
        .edge_inv(edge_inv), .edge_both(edge_both), .hit(hit)
    );

    slave_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hit(hit),
        .slv_mode(slv_mode), .trig_sel(trig_sel), .flag_clr(flag_clr),
        .tie(tie), .tde(tde), .run(run), .trig_evt(trig_evt),
        .trig_flag(trig_flag), .irq(irq), .dma_req(dma_req)
    );

    count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(trig_evt),
        .psc_div(psc_div), .arr(arr_act), .cnt(cnt), .ovf(ovf)
    );

    // R3, R7, R8: update sources
    assign load = ovf | (trig_evt & ~urs);

    preload_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(load), .arr_pre(arr_pre),
        .ccr_pre(ccr_pre), .arr_act(arr_act), .cmp_act(cmp_act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uev_q <= 1'b0;
        else        uev_q <= load;
    end
    assign uev = uev_q;

    a_r7_update: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && !urs) |=> (uev && arr_act == $past(arr_pre) && cnt == '0));
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && urs && !ovf) |=> (!uev && $stable(arr_act) && $stable(cmp_act)));
endmodule

// File: tb/sim_slave_reset_timer.sv
module sim_slave_reset_timer;
    logic        clk = 1'b0;
    logic        rst_n, cnt_en, trig_in, edge_inv, edge_both, urs, tie, tde, flag_clr;
    logic [2:0]  slv_mode;
    logic [4:0]  trig_sel;
    logic [15:0] psc_div, arr_pre, cnt, arr_act;
    logic [31:0] ccr_pre, cmp_act;
    logic        uev, trig_flag, irq, dma_req;

    int checks = 0;
    int fails  = 0;
    int arr_cur;

    always #4 clk = ~clk;

    slave_reset_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_in(trig_in),
        .edge_inv(edge_inv), .edge_both(edge_both), .slv_mode(slv_mode),
        .trig_sel(trig_sel), .urs(urs), .psc_div(psc_div), .arr_pre(arr_pre),
        .ccr_pre(ccr_pre), .tie(tie), .tde(tde), .flag_clr(flag_clr),
        .cnt(cnt), .uev(uev), .trig_flag(trig_flag), .irq(irq),
        .dma_req(dma_req), .arr_act(arr_act), .cmp_act(cmp_act)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // counter value after n steps at prescale 1
    function automatic int adv(input int c, input int a, input int n);
        int v = c;
        for (int i = 0; i < n; i++) v = (v == a) ? 0 : v + 1;
        return v;
    endfunction

    task automatic settle_low();
        trig_in = 1'b0;
        tick(4);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c;
        rst_n = 0; cnt_en = 0; trig_in = 0; edge_inv = 0; edge_both = 0;
        urs = 0; tie = 0; tde = 0; flag_clr = 0; psc_div = 0;
        slv_mode = 3'b100; trig_sel = 5'b00101;
        arr_pre = 16'h36; ccr_pre = {16'h0022, 16'h0011};
        tick(3);
        chk("R1 cnt", cnt, 0);
        chk("R1 flag", trig_flag, 0);
        chk("R1 uev", uev, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma", dma_req, 0);
        chk("R1 arr_act", arr_act, 16'hffff);
        chk("R1 cmp_act", cmp_act, 32'hffffffff);
        rst_n = 1;
        tick(2);
        chk("R2 idle", cnt, 0);

        cnt_en = 1;
        tick(10);
        chk("R2 count", cnt, 9);

        // R6/R7 restart with urs=0
        trig_in = 1;
        tick(2);
        chk("R6 before", cnt, 11);
        chk("R6 flag before", trig_flag, 0);
        tick(1);
        chk("R6 clear", cnt, 0);
        chk("R7 uev", uev, 1);
        chk("R7 arr_act", arr_act, 16'h36);
        chk("R7 cmp_act", cmp_act, 32'h00220011);
        chk("R9 flag set", trig_flag, 1);
        arr_pre = 16'h30;
        tick(1);
        chk("R6 restart", cnt, 1);
        chk("R7 uev single", uev, 0);

        // R3 wrap at 0x36
        tick(16'h35);
        chk("R3 top", cnt, 16'h36);
        chk("R3 no uev", uev, 0);
        tick(1);
        chk("R3 wrap", cnt, 0);
        chk("R3 uev", uev, 1);
        chk("R3 arr load", arr_act, 16'h30);
        arr_cur = 16'h30;

        // R5 sweep over edge settings and directions
        for (int cfg = 0; cfg < 3; cfg++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic hit_exp;
                edge_inv  = (cfg == 1);
                edge_both = (cfg == 2);
                trig_in = (dir == 0);
                tick(4);
                flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
                c = int'(cnt);
                trig_in = (dir == 1);
                tick(3);
                hit_exp = (cfg == 2) || (cfg == 0 && dir == 1) || (cfg == 1 && dir == 0);
                chk("R5 cnt", cnt, hit_exp ? 0 : adv(c, arr_cur, 3));
                chk("R5 flag", trig_flag, hit_exp);
            end
        end
        edge_inv = 0; edge_both = 0;

        // R8 urs=1
        settle_low();
        arr_pre = 16'h20; urs = 1;
        trig_in = 1;
        tick(3);
        chk("R8 cnt", cnt, 0);
        chk("R8 flag", trig_flag, 1);
        chk("R8 uev", uev, 0);
        chk("R8 arr kept", arr_act, 16'h30);
        urs = 0; arr_pre = 16'h30;

        // R9 sticky and collision
        tick(5);
        chk("R9 sticky", trig_flag, 1);
        flag_clr = 1; tick(1); flag_clr = 0;
        chk("R9 cleared", trig_flag, 0);
        settle_low();
        trig_in = 1;
        tick(2);
        chk("R9 pre", trig_flag, 0);
        flag_clr = 1; tick(1); flag_clr = 0;
        chk("R9 collide", trig_flag, 1);
        chk("R9 collide cnt", cnt, 0);

        // R10 irq and dma
        tie = 1; tde = 1;
        tick(1);
        chk("R10 irq on", irq, 1);
        settle_low();
        chk("R10 irq off", irq, 0);
        trig_in = 1;
        tick(2);
        chk("R10 dma idle", dma_req, 0);
        tick(1);
        chk("R10 dma pulse", dma_req, 1);
        chk("R10 irq set", irq, 1);
        tick(1);
        chk("R10 dma single", dma_req, 0);
        tie = 0; tde = 0;
        tick(1);
        chk("R10 irq masked", irq, 0);

        // R4 mode and source qualification
        slv_mode = 3'b000;
        settle_low();
        c = int'(cnt);
        trig_in = 1; tick(3);
        chk("R4 mode cnt", cnt, adv(c, arr_cur, 3));
        chk("R4 mode flag", trig_flag, 0);
        slv_mode = 3'b100; trig_sel = 5'b00000;
        settle_low();
        c = int'(cnt);
        trig_in = 1; tick(3);
        chk("R4 src cnt", cnt, adv(c, arr_cur, 3));
        chk("R4 src flag", trig_flag, 0);
        trig_sel = 5'b00101;

        // R11 stopped counter ignores triggers, R2 freeze
        settle_low();
        cnt_en = 0;
        tick(2);
        c = int'(cnt);
        tick(3);
        chk("R2 frozen", cnt, c);
        trig_in = 1; tick(4);
        chk("R11 cnt", cnt, c);
        chk("R11 flag", trig_flag, 0);
        cnt_en = 1;
        tick(1);
        chk("R2 start delay", cnt, c);
        tick(1);
        chk("R2 resume", cnt, adv(c, arr_cur, 1));

        // R6 prescaler restart with divide by 3
        psc_div = 2;
        settle_low();
        trig_in = 1; tick(3);
        chk("R6 psc clear", cnt, 0);
        tick(2);
        chk("R6 psc wait", cnt, 0);
        tick(1);
        chk("R6 psc first", cnt, 1);
        tick(3);
        chk("R2 psc period", cnt, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule